// File: doc/BRIEF.md
# Byte-Addressed Data-Space Front End with Per-Region Wait States

This block sits between a single requester and a small byte-wide data space that is split into three regions. The regions are a peripheral register window, a window onto nonvolatile data, and on-chip SRAM. The block decodes a 16-bit byte address and picks the region. It then holds off completion until that region's access time has passed, and reports completion with a `ready` strobe in the cycle in which read data is valid or a write is taken. Each region is modelled as a plain synchronous byte array. Addresses above the three regions are reported as errors.

A read request may instead be held as a burst. In that case the block walks the address upward by one byte per beat, at the rate of the region being read. SRAM delivers a byte every cycle and the nonvolatile window delivers one every other cycle. When the walk leaves a region, the next beat pays the full first-access latency of the region it enters. The lowest sixteen peripheral bytes also accept single-bit set, clear and test operations.

Top module: `dbus_front`

## Requirements
- R1: Byte address 0x0000–0x0FFF selects the peripheral region, 0x1000–0x1FFF selects the nonvolatile window, 0x2000–0x5FFF selects SRAM, and 0x6000–0xFFFF is unmapped.
- R2: A peripheral read or write completes in its first cycle: `ready` is high in the same cycle in which `req` is first presented.
- R3: An SRAM write completes in the first cycle. An SRAM single read completes in the second cycle, with the data on `rdata`.
- R4: A nonvolatile write completes in the first cycle. A nonvolatile single read completes in the third cycle.
- R5: An unmapped access completes in one cycle with `rdata` = 0x00 and `err` high for that cycle only. An unmapped write changes no stored byte.
- R6: `ready` and `err` are high only while `req` is high. `rdata` is 0x00 in every cycle that does not complete a read or a bit test. After reset, `ready`, `err` and `rdata` are low.
- R7: A burst is a read (`we`=0, `bitop`=0) with `burst` held high. In SRAM its first byte arrives with the single-read latency, and each following byte, at address +1, arrives in the next cycle.
- R8: In a nonvolatile burst the first byte arrives with the single-read latency, and each following byte arrives two cycles after the previous one.
- R9: When the burst address moves into another region, the burst rate is dropped. That byte takes the single-read latency of the new region, and streaming then resumes at the new region's rate.
- R10: `bitop` encodes 0 = none, 1 = set, 2 = clear, 3 = test, acting on bit `bitsel` of addresses 0x0000–0x000F in one cycle. A test returns that bit in `rdata[0]` with the other bits zero. A set or clear returns 0x00. A nonzero `bitop` takes precedence over `we`.
- R11: A nonzero `bitop` aimed at any address other than 0x0000–0x000F completes in one cycle with `err` high and changes no stored byte.
- R12: Every stored byte is 0x00 after reset. Each region stores IO_DEPTH/NV_DEPTH/SRAM_DEPTH bytes (64/256/1024 by default), indexed by the offset from the region base modulo the depth, so addresses that differ by a multiple of the depth alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request, held until `ready` |
| we | input | 1 | 1 = write, 0 = read |
| burst | input | 1 | Keep reading consecutive bytes while high |
| bitop | input | 2 | Bit operation: 0 none, 1 set, 2 clear, 3 test |
| bitsel | input | 3 | Bit index for `bitop` |
| addr | input | 16 | Byte address |
| wdata | input | 8 | Write data |
| ready | output | 1 | Access completes in this cycle |
| rdata | output | 8 | Read or test data, valid with `ready` |
| err | output | 1 | Unmapped access or misplaced bit operation |

## Verification
The wait counter and the burst cursor are the only state that shapes timing. A corrupted counter shows up within one access as `ready` arriving a cycle early or late relative to the region's latency. A stale cursor shows up on the next burst beat as a byte from the wrong address, or as a beat spacing that does not match the region. A misjudged streaming flag at a region crossing shows up as the first byte of the new region arriving too soon. Storage faults appear on the next read of the touched byte, or of its alias.

// File: rtl/dbus_map_pkg.sv
package dbus_map_pkg;

  typedef enum logic [1:0] {
    RG_IO   = 2'd0,
    RG_NV   = 2'd1,
    RG_SRAM = 2'd2,
    RG_NONE = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    BOP_NONE = 2'd0,
    BOP_SET  = 2'd1,
    BOP_CLR  = 2'd2,
    BOP_TEST = 2'd3
  } bitop_e;

  localparam logic [15:0] NV_BASE   = 16'h1000;
  localparam logic [15:0] SRAM_BASE = 16'h2000;
  localparam logic [15:0] MAP_END   = 16'h6000;
  localparam int          GP_COUNT  = 16;

  function automatic region_e region_of(input logic [15:0] a);
    if (a < NV_BASE)        return RG_IO;
    else if (a < SRAM_BASE) return RG_NV;
    else if (a < MAP_END)   return RG_SRAM;
    else                    return RG_NONE;
  endfunction

endpackage

// File: rtl/dbus_region_decode.sv
module dbus_region_decode
  import dbus_map_pkg::*;
#(
  parameter int IO_DEPTH   = 64,
  parameter int NV_DEPTH   = 256,
  parameter int SRAM_DEPTH = 1024,
  localparam int IO_AW = $clog2(IO_DEPTH),
  localparam int NV_AW = $clog2(NV_DEPTH),
  localparam int SR_AW = $clog2(SRAM_DEPTH)
) (
  input  logic [15:0]      addr,
  output logic [IO_AW-1:0] io_idx,
  output logic [NV_AW-1:0] nv_idx,
  output logic [SR_AW-1:0] sr_idx,
  output logic             gp_hit
);

  assign io_idx = IO_AW'(addr);
  assign nv_idx = NV_AW'(addr - NV_BASE);
  assign sr_idx = SR_AW'(addr - SRAM_BASE);
  assign gp_hit = (addr < 16'(GP_COUNT));

endmodule

// File: rtl/dbus_timing_ctrl.sv
module dbus_timing_ctrl
  import dbus_map_pkg::*;
#(
  parameter int CNT_W       = 2,
  parameter int IO_LAT      = 1,
  parameter int NV_RD_LAT   = 3,
  parameter int SRAM_RD_LAT = 2,
  parameter int WR_LAT      = 1,
  parameter int IO_GAP      = 1,
  parameter int NV_GAP      = 2,
  parameter int SRAM_GAP    = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        is_rd,
  input  logic        burst,
  input  logic [15:0] addr,
  output logic        ready,
  output logic [15:0] eff_addr,
  output region_e     rgn,
  output logic        use_cursor,
  output logic        streaming
);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic             stream_q;
  logic [15:0]      cursor_q;
  logic [15:0]      next_addr;
  region_e          next_rgn;
  int               need;

  function automatic int first_lat(input region_e r, input logic rd);
    if (r == RG_NONE) return 1;
    if (!rd)          return WR_LAT;
    case (r)
      RG_IO:   return IO_LAT;
      RG_NV:   return NV_RD_LAT;
      default: return SRAM_RD_LAT;
    endcase
  endfunction

  function automatic int beat_gap(input region_e r);
    case (r)
      RG_IO:   return IO_GAP;
      RG_NV:   return NV_GAP;
      RG_SRAM: return SRAM_GAP;
      default: return 1;
    endcase
  endfunction

  assign use_cursor = active_q && burst && is_rd;
  assign streaming  = use_cursor && stream_q;
  assign eff_addr   = use_cursor ? cursor_q : addr;
  assign rgn        = region_of(eff_addr);
  assign next_addr  = eff_addr + 16'd1;
  assign next_rgn   = region_of(next_addr);
  assign need       = streaming ? beat_gap(rgn) : first_lat(rgn, is_rd);
  assign ready      = req && (int'(cnt_q) == need - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      stream_q <= 1'b0;
      cursor_q <= '0;
    end else if (!req) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      stream_q <= 1'b0;
    end else if (!ready) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
      if (is_rd && burst) begin
        active_q <= 1'b1;
        cursor_q <= next_addr;
        stream_q <= (next_rgn == rgn) && (rgn != RG_NONE);
      end else begin
        active_q <= 1'b0;
        stream_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dbus_byte_store.sv
module dbus_byte_store #(
  parameter int DEPTH    = 64,
  parameter bit HAS_BITS = 1'b0,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] idx,
  input  logic [7:0]    wdata,
  input  logic          bit_en,
  input  logic          bit_val,
  input  logic [2:0]    bit_sel,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];
  logic       bit_go;

  generate
    if (HAS_BITS) begin : g_bits
      assign bit_go = bit_en;
    end else begin : g_nobits
      assign bit_go = bit_en & 1'b0;
    end
  endgenerate

  assign rdata = mem[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (wr_en) begin
      mem[idx] <= wdata;
    end else if (bit_go) begin
      mem[idx][bit_sel] <= bit_val;
    end
  end

endmodule

// File: rtl/dbus_front.sv
module dbus_front
  import dbus_map_pkg::*;
#(
  parameter int IO_DEPTH    = 64,
  parameter int NV_DEPTH    = 256,
  parameter int SRAM_DEPTH  = 1024,
  parameter int CNT_W       = 2,
  parameter int NV_RD_LAT   = 3,
  parameter int SRAM_RD_LAT = 2,
  parameter int NV_GAP      = 2,
  parameter int SRAM_GAP    = 1,
  localparam int IO_AW = $clog2(IO_DEPTH),
  localparam int NV_AW = $clog2(NV_DEPTH),
  localparam int SR_AW = $clog2(SRAM_DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic        burst,
  input  logic [1:0]  bitop,
  input  logic [2:0]  bitsel,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  output logic        ready,
  output logic [7:0]  rdata,
  output logic        err
);

  logic             is_bitop;
  logic             is_rd;
  logic [15:0]      eff_addr;
  region_e          cur_rgn;
  logic             use_cursor;
  logic             streaming;
  logic [IO_AW-1:0] io_idx;
  logic [NV_AW-1:0] nv_idx;
  logic [SR_AW-1:0] sr_idx;
  logic             gp_hit;
  logic             bad_bitop;
  logic             io_wr, nv_wr, sr_wr, io_bit;
  logic [7:0]       io_rd, nv_rd, sr_rd, region_rd;

  assign is_bitop = (bitop != BOP_NONE);
  assign is_rd    = !we && !is_bitop;

  dbus_timing_ctrl #(
    .CNT_W(CNT_W), .IO_LAT(1), .NV_RD_LAT(NV_RD_LAT), .SRAM_RD_LAT(SRAM_RD_LAT),
    .WR_LAT(1), .IO_GAP(1), .NV_GAP(NV_GAP), .SRAM_GAP(SRAM_GAP)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .is_rd(is_rd), .burst(burst),
    .addr(addr), .ready(ready), .eff_addr(eff_addr), .rgn(cur_rgn),
    .use_cursor(use_cursor), .streaming(streaming)
  );

  dbus_region_decode #(
    .IO_DEPTH(IO_DEPTH), .NV_DEPTH(NV_DEPTH), .SRAM_DEPTH(SRAM_DEPTH)
  ) u_dec (
    .addr(eff_addr), .io_idx(io_idx), .nv_idx(nv_idx), .sr_idx(sr_idx),
    .gp_hit(gp_hit)
  );

  assign bad_bitop = is_bitop && !(gp_hit && cur_rgn == RG_IO);
  assign io_wr  = ready && we && !is_bitop && (cur_rgn == RG_IO);
  assign nv_wr  = ready && we && !is_bitop && (cur_rgn == RG_NV);
  assign sr_wr  = ready && we && !is_bitop && (cur_rgn == RG_SRAM);
  assign io_bit = ready && is_bitop && !bad_bitop && (bitop != BOP_TEST);

  dbus_byte_store #(.DEPTH(IO_DEPTH), .HAS_BITS(1'b1)) u_io (
    .clk(clk), .rst_n(rst_n), .wr_en(io_wr), .idx(io_idx), .wdata(wdata),
    .bit_en(io_bit), .bit_val(bitop == BOP_SET), .bit_sel(bitsel), .rdata(io_rd)
  );

  dbus_byte_store #(.DEPTH(NV_DEPTH), .HAS_BITS(1'b0)) u_nv (
    .clk(clk), .rst_n(rst_n), .wr_en(nv_wr), .idx(nv_idx), .wdata(wdata),
    .bit_en(1'b0), .bit_val(1'b0), .bit_sel(3'd0), .rdata(nv_rd)
  );

  dbus_byte_store #(.DEPTH(SRAM_DEPTH), .HAS_BITS(1'b0)) u_sram (
    .clk(clk), .rst_n(rst_n), .wr_en(sr_wr), .idx(sr_idx), .wdata(wdata),
    .bit_en(1'b0), .bit_val(1'b0), .bit_sel(3'd0), .rdata(sr_rd)
  );

  always_comb begin
    case (cur_rgn)
      RG_IO:   region_rd = io_rd;
      RG_NV:   region_rd = nv_rd;
      RG_SRAM: region_rd = sr_rd;
      default: region_rd = 8'h00;
    endcase
  end

  always_comb begin
    rdata = 8'h00;
    if (ready) begin
      if (is_rd)                                  rdata = region_rd;
      else if (bitop == BOP_TEST && !bad_bitop)   rdata = {7'b0, io_rd[bitsel]};
    end
  end

  assign err = ready && ((cur_rgn == RG_NONE) || bad_bitop);

endmodule

// File: rtl/dbus_front_chk.sv
module dbus_front_chk
  import dbus_map_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req,
  input logic       we,
  input logic [1:0] bitop,
  input logic       ready,
  input logic       err,
  input logic [7:0] rdata,
  input logic       use_cursor,
  input logic       streaming,
  input region_e    cur_rgn
);

  logic rd;
  assign rd = !we && (bitop == 2'd0);

  // R6
  ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> req);

  // R5
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (ready && rdata == 8'h00));

  // R2
  io_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && cur_rgn == RG_IO && !use_cursor) |-> ready);

  // R3
  write_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we) |-> ready);

  // R3
  sram_rd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && rd && !use_cursor && cur_rgn == RG_SRAM) |-> ($past(req) && !$past(ready)));

  // R4
  nv_rd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && rd && !use_cursor && cur_rgn == RG_NV)
      |-> ($past(req, 2) && !$past(ready) && !$past(ready, 2)));

  // R7
  sram_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && streaming && cur_rgn == RG_SRAM) |-> ready);

  // R8
  nv_stream_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && streaming && cur_rgn == RG_NV) |-> !$past(ready));

endmodule

bind dbus_front dbus_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .bitop(bitop),
  .ready(ready), .err(err), .rdata(rdata), .use_cursor(use_cursor),
  .streaming(streaming), .cur_rgn(cur_rgn)
);

// File: tb/test_dbus_front.sv
module test_dbus_front;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, burst = 1'b0;
  logic [1:0]  bitop = 2'd0;
  logic [2:0]  bitsel = 3'd0;
  logic [15:0] addr = 16'h0;
  logic [7:0]  wdata = 8'h0;
  logic        ready, err;
  logic [7:0]  rdata;

  int checks = 0;
  int failures = 0;
  logic [7:0] shadow [logic [15:0]];

  always #2 clk = ~clk;

  dbus_front i_dbus_front (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .burst(burst),
    .bitop(bitop), .bitsel(bitsel), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .err(err)
  );

  // bench-side address map: 0 periph, 1 nonvolatile, 2 sram, 3 unmapped
  function automatic int b_rgn(input logic [15:0] a);
    if (a <= 16'h0FFF) return 0;
    if (a <= 16'h1FFF) return 1;
    if (a <= 16'h5FFF) return 2;
    return 3;
  endfunction

  function automatic int b_first(input int r);
    return (r == 1) ? 3 : (r == 2) ? 2 : 1;
  endfunction

  function automatic int b_gap(input int r);
    return (r == 1) ? 2 : 1;
  endfunction

  function automatic logic [15:0] canon(input logic [15:0] a);
    case (b_rgn(a))
      0:       return a & 16'h003F;
      1:       return 16'h1000 + (a & 16'h00FF);
      2:       return 16'h2000 + ((a - 16'h2000) & 16'h03FF);
      default: return a;
    endcase
  endfunction

  function automatic logic [7:0] sh_get(input logic [15:0] a);
    logic [15:0] k = canon(a);
    if (b_rgn(a) == 3) return 8'h00;
    return shadow.exists(k) ? shadow[k] : 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_access(input logic w, input logic [1:0] bop, input logic [2:0] bsel,
                           input logic [15:0] a, input logic [7:0] d, input string tag);
    int r;
    int elat;
    int lat;
    logic [7:0] erd, cur, grd;
    logic eerr, gerr;
    bit got;
    r    = b_rgn(a);
    cur  = sh_get(a);
    eerr = (r == 3) || (bop != 2'd0 && a >= 16'd16);
    elat = (w || bop != 2'd0 || r == 3) ? 1 : b_first(r);
    erd  = 8'h00;
    if (!eerr) begin
      if (bop == 2'd3) erd = {7'b0, cur[bsel]};
      else if (bop == 2'd1) begin cur[bsel] = 1'b1; shadow[canon(a)] = cur; end
      else if (bop == 2'd2) begin cur[bsel] = 1'b0; shadow[canon(a)] = cur; end
      else if (w) shadow[canon(a)] = d;
      else erd = cur;
    end
    @(negedge clk);
    req = 1'b1; we = w; bitop = bop; bitsel = bsel; addr = a; wdata = d; burst = 1'b0;
    got = 0; lat = 0; grd = 8'h00; gerr = 1'b0;
    for (int c = 1; c <= 6 && !got; c++) begin
      #1;
      if (ready) begin got = 1; lat = c; grd = rdata; gerr = err; end
      @(negedge clk);
    end
    req = 1'b0; we = 1'b0; bitop = 2'd0;
    chk({tag, " latency"}, lat, elat);
    chk({tag, " data"}, grd, erd);
    chk({tag, " err"}, gerr, eerr);
    if (eerr) begin
      #1 chk({tag, " R5 err one cycle"}, err, 1'b0);
    end
  endtask

  task automatic do_burst(input logic [15:0] a, input int n, input string tag);
    int cyc, k, exp_cyc;
    logic [15:0] ba;
    cyc = 0; k = 0;
    exp_cyc = b_first(b_rgn(a));
    @(negedge clk);
    req = 1'b1; burst = 1'b1; we = 1'b0; bitop = 2'd0; addr = a;
    while (k < n && cyc < 60) begin
      cyc++;
      #1;
      if (ready) begin
        ba = a + 16'(k);
        chk({tag, " beat cycle"}, cyc, exp_cyc);
        chk({tag, " beat data"}, rdata, sh_get(ba));
        chk({tag, " beat err"}, err, b_rgn(ba) == 3);
        k++;
        if (k < n) begin
          if (b_rgn(ba + 16'd1) != b_rgn(ba) || b_rgn(ba + 16'd1) == 3)
            exp_cyc += b_first(b_rgn(ba + 16'd1));
          else
            exp_cyc += b_gap(b_rgn(ba + 16'd1));
        end
      end else begin
        chk({tag, " R6 idle rdata"}, rdata, 8'h00);
      end
      @(negedge clk);
    end
    req = 1'b0; burst = 1'b0;
    chk({tag, " beat count"}, k, n);
  endtask

  task automatic t_reset;
    #1;
    chk("R6 reset ready", ready, 1'b0);
    chk("R6 reset err", err, 1'b0);
    chk("R6 reset rdata", rdata, 8'h00);
    do_access(0, 2'd0, 3'd0, 16'h0005, 8'h00, "R12 reset content periph");
    do_access(0, 2'd0, 3'd0, 16'h2100, 8'h00, "R12 reset content sram");
  endtask

  task automatic t_regions;
    do_access(1, 2'd0, 3'd0, 16'h0030, 8'h3C, "R2 periph write");
    do_access(0, 2'd0, 3'd0, 16'h0030, 8'h00, "R2 periph read");
    do_access(1, 2'd0, 3'd0, 16'h0FFF, 8'hC3, "R1 periph top write");
    do_access(0, 2'd0, 3'd0, 16'h0FFF, 8'h00, "R1 periph top read");
    do_access(1, 2'd0, 3'd0, 16'h2010, 8'h77, "R3 sram write");
    do_access(0, 2'd0, 3'd0, 16'h2010, 8'h00, "R3 sram read");
    do_access(1, 2'd0, 3'd0, 16'h5FFF, 8'h9E, "R1 sram top write");
    do_access(0, 2'd0, 3'd0, 16'h5FFF, 8'h00, "R1 sram top read");
    do_access(1, 2'd0, 3'd0, 16'h1000, 8'h11, "R4 nv base write");
    do_access(1, 2'd0, 3'd0, 16'h1FFF, 8'h22, "R4 nv top write");
    do_access(0, 2'd0, 3'd0, 16'h1000, 8'h00, "R4 nv base read");
    do_access(0, 2'd0, 3'd0, 16'h1FFF, 8'h00, "R1 nv top read");
  endtask

  task automatic t_unmapped;
    do_access(1, 2'd0, 3'd0, 16'h2000, 8'h99, "R3 sram preload");
    do_access(0, 2'd0, 3'd0, 16'h6000, 8'h00, "R5 unmapped read");
    do_access(1, 2'd0, 3'd0, 16'h6000, 8'hEE, "R5 unmapped write");
    do_access(1, 2'd0, 3'd0, 16'hFFFF, 8'hEF, "R5 unmapped high write");
    do_access(0, 2'd0, 3'd0, 16'h2000, 8'h00, "R5 alias target unchanged");
  endtask

  task automatic t_bits;
    do_access(1, 2'd0, 3'd0, 16'h0002, 8'h00, "R10 gp clear byte");
    do_access(0, 2'd1, 3'd3, 16'h0002, 8'h00, "R10 set bit3");
    do_access(0, 2'd3, 3'd3, 16'h0002, 8'h00, "R10 test bit3 high");
    do_access(0, 2'd0, 3'd0, 16'h0002, 8'h00, "R10 byte after set");
    do_access(1, 2'd2, 3'd3, 16'h0002, 8'hFF, "R10 clear bit3 with we");
    do_access(0, 2'd3, 3'd3, 16'h0002, 8'h00, "R10 test bit3 low");
    do_access(0, 2'd1, 3'd7, 16'h000F, 8'h00, "R10 set top gp bit7");
    do_access(0, 2'd0, 3'd0, 16'h000F, 8'h00, "R10 top gp byte");
    do_access(1, 2'd0, 3'd0, 16'h0020, 8'h5A, "R11 preload");
    do_access(0, 2'd1, 3'd0, 16'h0020, 8'h00, "R11 set outside gp");
    do_access(0, 2'd0, 3'd0, 16'h0020, 8'h00, "R11 byte unchanged");
    do_access(0, 2'd2, 3'd1, 16'h0010, 8'h00, "R11 clear at 0x10");
  endtask

  task automatic t_alias;
    do_access(1, 2'd0, 3'd0, 16'h2405, 8'h6B, "R12 sram alias write");
    do_access(0, 2'd0, 3'd0, 16'h2005, 8'h00, "R12 sram alias read");
    do_access(1, 2'd0, 3'd0, 16'h1107, 8'h4D, "R12 nv alias write");
    do_access(0, 2'd0, 3'd0, 16'h1007, 8'h00, "R12 nv alias read");
  endtask

  task automatic t_bursts;
    for (int i = 0; i < 4; i++)
      do_access(1, 2'd0, 3'd0, 16'h2000 + 16'(i), 8'hA0 + 8'(i), "R7 preload");
    for (int i = 0; i < 3; i++)
      do_access(1, 2'd0, 3'd0, 16'h1000 + 16'(i), 8'h50 + 8'(i), "R8 preload");
    do_access(1, 2'd0, 3'd0, 16'h1FFE, 8'h3E, "R9 preload");
    do_access(1, 2'd0, 3'd0, 16'h5FFE, 8'hB7, "R9 preload top");
    do_burst(16'h2000, 4, "R7 sram burst");
    do_burst(16'h1000, 3, "R8 nv burst");
    do_burst(16'h1FFE, 4, "R9 nv to sram burst");
    do_burst(16'h5FFE, 3, "R9 sram to unmapped burst");
    do_burst(16'h0FFF, 3, "R9 periph to nv burst");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regions();
    t_unmapped();
    t_bits();
    t_alias();
    t_bursts();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R6 watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule